// File: doc/BRIEF.md
# Interleaved Host-to-Device Address Decoder

This block is one host-managed decoder window placed in front of a small word-addressed memory. Software programs a 64-bit window base, a 64-bit window size and a control word through a 32-bit register port. The control word carries an interleave granularity code, an interleave ways code, and a commit request. Once the window is committed, each host memory request is checked against the window. A request that lands inside the window has its offset converted into a device address by taking out the way-select bits, and the request then reaches the local storage array.

A request that falls outside the window, arrives before a commit, or translates past the end of the storage array is a miss. A read that misses returns an error response with zero data. A write that misses completes with a normal response and changes nothing. Every memory request gets exactly one response one cycle later. The response carries the translated device address whenever the window was hit.

Top module: `intlv_mem_decoder`

## Requirements
- R1: After reset, all five registers read as zero, and no memory response is pending.
- R2: A full-width write (byte enables 4'hF) is stored at its offset and reads back unchanged. The offsets are: 0x00 base low, 0x04 base high, 0x08 size low, 0x0C size high, 0x10 control. The control word holds granularity code IG at bits [3:0], ways code IW at bits [7:4], commit at bit 8, committed at bit 9 and error at bit 10. A control write with bit 8 clear is stored exactly as written.
- R3: A register access whose byte enables are not 4'hF is ignored. A write changes no register, and a read returns zero.
- R4: A full-width control write with bit 8 set stores the word with bit 8 cleared, bit 10 cleared and bit 9 set. All other bits are kept as written.
- R5: While control bit 9 is clear, every memory request is a miss.
- R6: A host address below the 64-bit base is a miss.
- R7: A host address whose offset from the base is greater than or equal to the size is a miss. The offset base+size-4 still hits.
- R8: On a hit, the device address keeps offset bits [7+IG:0]. Offset bits from position 8+IG+IW upward are moved down by IW places and placed directly above them. The device address is reported on `mem_rsp_dpa`, which reads zero on a miss.
- R9: A read that misses, or whose device address is at or beyond MEM_WORDS*4 bytes, responds with error set and zero data. A read that hits returns the word last written to that device address.
- R10: A write that misses, or whose device address is beyond the storage, responds without error and leaves the storage unchanged.
- R11: Each memory request produces exactly one response, in the following cycle. Back-to-back requests are accepted every cycle.
- R12: A register access to an undefined or unaligned offset is ignored. A write there has no effect, and a read there returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | Register write (1) or read (0) |
| reg_be | input | 4 | Register byte enables; only 4'hF is accepted |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| mem_req | input | 1 | Memory request strobe |
| mem_we | input | 1 | Memory write (1) or read (0) |
| mem_hpa | input | 64 | Host byte address, word aligned |
| mem_wdata | input | 32 | Memory write data |
| mem_rsp_valid | output | 1 | Response valid, one cycle after the request |
| mem_rsp_err | output | 1 | Read error response |
| mem_rsp_dpa | output | 64 | Translated device address on hit, else zero |
| mem_rsp_rdata | output | 32 | Read data, zero on error |

## Verification
The hardest case to reach is a write that is dropped without any sign. Its response looks exactly like a successful write, so the only evidence is the storage contents afterwards. The stimulus first stores a known word under a committed window. It then withdraws the commit, or aims a write one word past the storage end so that a truncated index would alias onto that word, and sends new data. Finally it re-commits and reads the word back through a hitting address. The interleave sweep covers all nine granularity and ways pairs from 0 to 2, using offsets whose way-select bits differ so that the shifted upper field is exercised.

// File: rtl/intlv_pkg.sv
package intlv_pkg;
  localparam int REG_AW = 5;
  localparam int NREG   = 5;
  localparam int IDX_CTRL = 4;

  // Register offsets (byte addresses)
  localparam logic [REG_AW-1:0] OFS_BASE_LO = 5'h00;
  localparam logic [REG_AW-1:0] OFS_BASE_HI = 5'h04;
  localparam logic [REG_AW-1:0] OFS_SIZE_LO = 5'h08;
  localparam logic [REG_AW-1:0] OFS_SIZE_HI = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_CTRL    = 5'h10;

  // Control word field positions
  localparam int CTL_IG_LSB    = 0;
  localparam int CTL_IW_LSB    = 4;
  localparam int CTL_CODE_W    = 4;
  localparam int CTL_COMMIT    = 8;
  localparam int CTL_COMMITTED = 9;
  localparam int CTL_ERR       = 10;

  // Base granule of interleave, as a power of two in bytes
  localparam int GRAN_BASE_LOG2 = 8;

  typedef struct packed {
    logic [63:0]           base;
    logic [63:0]           size;
    logic [CTL_CODE_W-1:0] ig;
    logic [CTL_CODE_W-1:0] iw;
    logic                  committed;
  } win_cfg_t;
endpackage

// File: rtl/intlv_regs.sv
module intlv_regs
  import intlv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [3:0]        be,
  input  logic [REG_AW-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output win_cfg_t          cfg,
  output logic [31:0]       ctrl_word
);
  localparam int IDX_W = REG_AW - 2;

  logic [31:0]      regs_q [NREG];
  logic             full_acc;
  logic             ofs_ok;
  logic [IDX_W-1:0] idx;
  logic [31:0]      ctrl_wr_val;

  assign idx      = addr[REG_AW-1:2];
  assign ofs_ok   = (addr[1:0] == 2'b00) && (int'(idx) < NREG);
  assign full_acc = sel && (be == 4'hF) && ofs_ok;

  // Commit handling applied to the value entering the control register
  always_comb begin
    ctrl_wr_val = wdata;
    if (wdata[CTL_COMMIT]) begin
      ctrl_wr_val[CTL_COMMIT]    = 1'b0;
      ctrl_wr_val[CTL_ERR]       = 1'b0;
      ctrl_wr_val[CTL_COMMITTED] = 1'b1;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic        wr_en;
    logic [31:0] reg_d;
    assign wr_en = full_acc && we && (int'(idx) == g);
    assign reg_d = (g == IDX_CTRL) ? ctrl_wr_val : wdata;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (wr_en) begin
        regs_q[g] <= reg_d;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (full_acc && !we) begin
      rdata = regs_q[idx];
    end
  end

  assign ctrl_word     = regs_q[IDX_CTRL];
  assign cfg.base      = {regs_q[int'(OFS_BASE_HI) >> 2], regs_q[int'(OFS_BASE_LO) >> 2]};
  assign cfg.size      = {regs_q[int'(OFS_SIZE_HI) >> 2], regs_q[int'(OFS_SIZE_LO) >> 2]};
  assign cfg.ig        = ctrl_word[CTL_IG_LSB +: CTL_CODE_W];
  assign cfg.iw        = ctrl_word[CTL_IW_LSB +: CTL_CODE_W];
  assign cfg.committed = ctrl_word[CTL_COMMITTED];
endmodule

// File: rtl/intlv_xlate.sv
module intlv_xlate
  import intlv_pkg::*;
(
  input  win_cfg_t    cfg,
  input  logic [63:0] hpa,
  output logic        hit,
  output logic [63:0] dpa
);
  logic [63:0] off;
  logic [6:0]  lo_w;
  logic [6:0]  hi_lsb;
  logic [63:0] low_mask;

  assign off      = hpa - cfg.base;
  assign lo_w     = 7'(GRAN_BASE_LOG2) + {3'b000, cfg.ig};
  assign hi_lsb   = lo_w + {3'b000, cfg.iw};
  assign low_mask = (64'd1 << lo_w) - 64'd1;

  // Keep the in-granule bits, drop the way-select bits, close the gap
  assign dpa = (off & low_mask) | ((off >> hi_lsb) << lo_w);
  assign hit = cfg.committed && (hpa >= cfg.base) && (off < cfg.size);
endmodule

// File: rtl/intlv_media.sv
module intlv_media #(
  parameter int WORDS = 1024,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] idx,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);
  logic [31:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store[idx] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= store[idx];
    end
  end
endmodule

// File: rtl/intlv_mem_decoder.sv
module intlv_mem_decoder
  import intlv_pkg::*;
#(
  parameter int MEM_WORDS = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [3:0]        reg_be,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              mem_req,
  input  logic              mem_we,
  input  logic [63:0]       mem_hpa,
  input  logic [31:0]       mem_wdata,
  output logic              mem_rsp_valid,
  output logic              mem_rsp_err,
  output logic [63:0]       mem_rsp_dpa,
  output logic [31:0]       mem_rsp_rdata
);
  localparam int MEM_AW   = $clog2(MEM_WORDS);
  localparam int BYTE_AW  = MEM_AW + 2;

  logic [1:0]  rst_sync_q;
  logic        core_rst_n;
  win_cfg_t    cfg;
  logic [31:0] ctrl_word;
  logic [63:0] win_base;
  logic        win_hit;
  logic [63:0] xl_dpa;
  logic        in_media;
  logic        acc_ok;
  logic [31:0] media_rdata;

  logic        rsp_valid_d, rsp_valid_q;
  logic        rsp_err_d,   rsp_err_q;
  logic        rsp_rd_d,    rsp_rd_q;
  logic [63:0] rsp_dpa_d,   rsp_dpa_q;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign core_rst_n = rst_sync_q[1];

  intlv_regs u_regs (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .sel       (reg_sel),
    .we        (reg_we),
    .be        (reg_be),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .cfg       (cfg),
    .ctrl_word (ctrl_word)
  );

  assign win_base = cfg.base;

  intlv_xlate u_xlate (
    .cfg (cfg),
    .hpa (mem_hpa),
    .hit (win_hit),
    .dpa (xl_dpa)
  );

  assign in_media = ((xl_dpa >> BYTE_AW) == 64'd0);
  assign acc_ok   = win_hit && in_media;

  intlv_media #(.WORDS(MEM_WORDS)) u_media (
    .clk   (clk),
    .rst_n (core_rst_n),
    .wr_en (mem_req && mem_we && acc_ok),
    .rd_en (mem_req && !mem_we && acc_ok),
    .idx   (xl_dpa[BYTE_AW-1:2]),
    .wdata (mem_wdata),
    .rdata (media_rdata)
  );

  // Response next-state
  always_comb begin
    rsp_valid_d = mem_req;
    rsp_err_d   = mem_req && !mem_we && !acc_ok;
    rsp_rd_d    = mem_req && !mem_we && acc_ok;
    rsp_dpa_d   = (mem_req && win_hit) ? xl_dpa : 64'd0;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rd_q    <= 1'b0;
      rsp_dpa_q   <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_err_q   <= rsp_err_d;
      rsp_rd_q    <= rsp_rd_d;
      rsp_dpa_q   <= rsp_dpa_d;
    end
  end

  assign mem_rsp_valid = rsp_valid_q;
  assign mem_rsp_err   = rsp_err_q;
  assign mem_rsp_dpa   = rsp_dpa_q;
  assign mem_rsp_rdata = rsp_rd_q ? media_rdata : 32'd0;
endmodule

// File: rtl/intlv_mem_decoder_chk.sv
module intlv_mem_decoder_chk
  import intlv_pkg::*;
(
  input logic              clk,
  input logic              core_rst_n,
  input logic              reg_sel,
  input logic              reg_we,
  input logic [3:0]        reg_be,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              mem_req,
  input logic              mem_we,
  input logic [63:0]       mem_hpa,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_err,
  input logic [63:0]       mem_rsp_dpa,
  input logic [31:0]       mem_rsp_rdata,
  input logic [63:0]       win_base,
  input logic [31:0]       ctrl_word
);
  AST_PARTIAL_IGNORED: assert property (@(posedge clk) disable iff (!core_rst_n)
    (reg_sel && reg_we && reg_be != 4'hF) |=> ($stable(ctrl_word) && $stable(win_base))); // R3

  AST_COMMIT_SETS: assert property (@(posedge clk) disable iff (!core_rst_n)
    (reg_sel && reg_we && reg_be == 4'hF && reg_addr == OFS_CTRL && reg_wdata[CTL_COMMIT])
    |=> (ctrl_word[CTL_COMMITTED] && !ctrl_word[CTL_COMMIT] && !ctrl_word[CTL_ERR])); // R4

  AST_UNCOMMITTED_MISS: assert property (@(posedge clk) disable iff (!core_rst_n)
    (mem_req && !ctrl_word[CTL_COMMITTED])
    |=> (mem_rsp_dpa == 64'd0 && (mem_rsp_err || $past(mem_we)))); // R5

  AST_BELOW_BASE: assert property (@(posedge clk) disable iff (!core_rst_n)
    (mem_req && !mem_we && mem_hpa < win_base) |=> mem_rsp_err); // R6

  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!core_rst_n)
    (mem_rsp_valid && mem_rsp_err) |-> (mem_rsp_rdata == 32'd0)); // R9

  AST_WRITE_OK: assert property (@(posedge clk) disable iff (!core_rst_n)
    (mem_req && mem_we) |=> (mem_rsp_valid && !mem_rsp_err)); // R10

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!core_rst_n)
    mem_req |=> mem_rsp_valid); // R11

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!core_rst_n)
    !mem_req |=> !mem_rsp_valid); // R11
endmodule

bind intlv_mem_decoder intlv_mem_decoder_chk u_chk (
  .clk           (clk),
  .core_rst_n    (core_rst_n),
  .reg_sel       (reg_sel),
  .reg_we        (reg_we),
  .reg_be        (reg_be),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .mem_req       (mem_req),
  .mem_we        (mem_we),
  .mem_hpa       (mem_hpa),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_err   (mem_rsp_err),
  .mem_rsp_dpa   (mem_rsp_dpa),
  .mem_rsp_rdata (mem_rsp_rdata),
  .win_base      (win_base),
  .ctrl_word     (ctrl_word)
);

// File: tb/intlv_mem_decoder_tb.sv
module intlv_mem_decoder_tb;
  localparam int MEM_WORDS = 1024;
  localparam logic [63:0] MEM_BYTES = 64'(MEM_WORDS * 4);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_we = 1'b0;
  logic [3:0]  reg_be = 4'h0;
  logic [4:0]  reg_addr = 5'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        mem_req = 1'b0, mem_we = 1'b0;
  logic [63:0] mem_hpa = 64'h0;
  logic [31:0] mem_wdata = 32'h0;
  logic        mem_rsp_valid, mem_rsp_err;
  logic [63:0] mem_rsp_dpa;
  logic [31:0] mem_rsp_rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench-side model
  logic [63:0] m_base = 0, m_size = 0;
  int          m_ig = 0, m_iw = 0;
  bit          m_comm = 0;
  logic [31:0] mm [longint];

  // scoreboard queues
  string       q_tag [$];
  bit          q_err [$];
  logic [63:0] q_dpa [$];
  bit          q_chk [$];
  logic [31:0] q_data [$];

  always #10 clk = ~clk;

  intlv_mem_decoder #(.MEM_WORDS(MEM_WORDS)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_be(reg_be), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_hpa(mem_hpa), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
    .mem_rsp_dpa(mem_rsp_dpa), .mem_rsp_rdata(mem_rsp_rdata)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
    reg_sel = 1; reg_we = 1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_sel = 0; reg_we = 0;
  endtask

  task automatic reg_rd(input logic [4:0] a, input logic [3:0] be, input logic [31:0] exp, input string tag);
    reg_sel = 1; reg_we = 0; reg_addr = a; reg_be = be;
    #1;
    check(reg_rdata === exp, tag, 64'(reg_rdata), 64'(exp));
    @(negedge clk);
    reg_sel = 0;
  endtask

  task automatic set_ctrl(input int ig, input int iw, input bit commit, input bit comm_bit, input logic [31:0] extra);
    logic [31:0] w;
    w = extra | 32'(ig) | (32'(iw) << 4) | (32'(commit) << 8) | (32'(comm_bit) << 9);
    reg_wr(5'h10, w, 4'hF);
    m_ig = ig; m_iw = iw;
    m_comm = commit ? 1'b1 : comm_bit;
  endtask

  task automatic set_window(input logic [63:0] b, input logic [63:0] s);
    reg_wr(5'h00, b[31:0], 4'hF);  reg_wr(5'h04, b[63:32], 4'hF);
    reg_wr(5'h08, s[31:0], 4'hF);  reg_wr(5'h0C, s[63:32], 4'hF);
    m_base = b; m_size = s;
  endtask

  // Reference translation written arithmetically
  function automatic logic [63:0] ref_dpa(input logic [63:0] off);
    logic [63:0] gran, low, up;
    gran = 64'd1 << (8 + m_ig);
    low  = off % gran;
    up   = off >> (8 + m_ig + m_iw);
    return up * gran + low;
  endfunction

  // Driver: computes the expectation, pushes it, drives one request cycle
  task automatic mem_acc(input bit we, input logic [63:0] hpa, input logic [31:0] wd, input string tag);
    logic [63:0] off, d;
    bit hit, ok;
    off = hpa - m_base;
    hit = m_comm && (hpa >= m_base) && (off < m_size);
    d   = hit ? ref_dpa(off) : 64'd0;
    ok  = hit && (d < MEM_BYTES);
    q_tag.push_back(tag);
    q_err.push_back(!we && !ok);
    q_dpa.push_back(d);
    if (!we && ok && mm.exists(longint'(d >> 2))) begin
      q_chk.push_back(1); q_data.push_back(mm[longint'(d >> 2)]);
    end else if (!we && !ok) begin
      q_chk.push_back(1); q_data.push_back(32'd0);
    end else begin
      q_chk.push_back(0); q_data.push_back(32'd0);
    end
    if (we && ok) mm[longint'(d >> 2)] = wd;
    mem_req = 1; mem_we = we; mem_hpa = hpa; mem_wdata = wd;
    @(negedge clk);
    mem_req = 0; mem_we = 0;
  endtask

  task automatic idle(input int n);
    mem_req = 0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops and compares responses (R11 on unexpected responses)
  always @(negedge clk) begin
    if (rst_n && mem_rsp_valid) begin
      if (q_tag.size() == 0) begin
        check(0, "R11 unexpected response", 64'd1, 64'd0);
      end else begin
        string t; bit e; logic [63:0] dp; bit c; logic [31:0] dv;
        t = q_tag.pop_front(); e = q_err.pop_front(); dp = q_dpa.pop_front();
        c = q_chk.pop_front(); dv = q_data.pop_front();
        check(mem_rsp_err === e, {t, " err"}, 64'(mem_rsp_err), 64'(e));
        check(mem_rsp_dpa === dp, {t, " dpa"}, mem_rsp_dpa, dp);
        if (c) check(mem_rsp_rdata === dv, {t, " data"}, 64'(mem_rsp_rdata), 64'(dv));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int offs [6] = '{'h0, 'h10C, 'h2F4, 'h5A8, 'hB3C, 'hFFC};
    logic [63:0] b;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(mem_rsp_valid === 1'b0, "R1 rsp_valid", 64'(mem_rsp_valid), 0);
    for (int i = 0; i < 5; i++) reg_rd(5'(i * 4), 4'hF, 32'h0, "R1 reset reg");

    // R5 uncommitted access with a valid window
    b = 64'h0000_0001_0000_4000;
    set_window(b, 64'h10000);
    mem_acc(0, b, 0, "R5 read before commit");
    mem_acc(1, b + 8, 32'h1111, "R5 write before commit");
    idle(2);

    // R2 readback of each register, control stored as written
    reg_rd(5'h00, 4'hF, 32'h0000_4000, "R2 base lo");
    reg_rd(5'h04, 4'hF, 32'h0000_0001, "R2 base hi");
    reg_rd(5'h08, 4'hF, 32'h0001_0000, "R2 size lo");
    reg_rd(5'h0C, 4'hF, 32'h0, "R2 size hi");
    set_ctrl(1, 2, 0, 0, 32'h5A00_0400);
    reg_rd(5'h10, 4'hF, 32'h5A00_0421, "R2 ctrl as written");

    // R3 partial accesses
    reg_wr(5'h00, 32'hDEAD_BEEF, 4'h3);
    reg_rd(5'h00, 4'hF, 32'h0000_4000, "R3 partial write ignored");
    reg_rd(5'h00, 4'h1, 32'h0, "R3 partial read zero");

    // R12 undefined / unaligned offsets
    reg_wr(5'h14, 32'hFFFF_FFFF, 4'hF);
    reg_rd(5'h14, 4'hF, 32'h0, "R12 undefined read");
    reg_wr(5'h02, 32'hFFFF_FFFF, 4'hF);
    reg_rd(5'h00, 4'hF, 32'h0000_4000, "R12 unaligned write ignored");
    reg_rd(5'h04, 4'hF, 32'h0000_0001, "R12 neighbour unchanged");

    // R4 commit handshake
    set_ctrl(1, 2, 1, 0, 32'h5A00_0400);
    reg_rd(5'h10, 4'hF, 32'h5A00_0221, "R4 commit self-clears");

    // R8 R9 sweep, back-to-back writes then reads (R11)
    for (int ig = 0; ig <= 2; ig++) begin
      for (int iw = 0; iw <= 2; iw++) begin
        set_ctrl(ig, iw, 1, 0, 32'h0);
        for (int k = 0; k < 6; k++)
          mem_acc(1, b + 64'(offs[k]), 32'(ig * 256 + iw * 16 + k) ^ 32'hC0DE_0000, "R8 sweep write");
        for (int k = 0; k < 6; k++)
          mem_acc(0, b + 64'(offs[k]), 0, "R8 R9 sweep read");
        idle(1);
      end
    end

    // R7 window end boundary
    set_ctrl(0, 0, 1, 0, 32'h0);
    set_window(b, 64'h800);
    mem_acc(1, b + 64'h7FC, 32'hB0B0_0001, "R7 last word write");
    mem_acc(0, b + 64'h7FC, 0, "R7 last word hits");
    mem_acc(0, b + 64'h800, 0, "R7 size boundary misses");
    idle(1);

    // R6 below base (differs in both halves)
    mem_acc(0, b - 64'd4, 0, "R6 just below base");
    mem_acc(0, 64'h0000_0000_FFFF_FFFC, 0, "R6 below base high half");
    idle(1);

    // R9 R10 beyond the storage end, with alias probe at device address 0
    set_window(b, 64'h10000);
    mem_acc(1, b, 32'hA11A_5000, "R10 seed word 0");
    mem_acc(0, b + MEM_BYTES, 0, "R9 read beyond storage");
    mem_acc(1, b + MEM_BYTES, 32'hBAD0_0BAD, "R10 write beyond storage ok");
    mem_acc(0, b, 0, "R10 word 0 unchanged");
    idle(1);

    // R5 R10 dropped write while uncommitted
    set_ctrl(0, 0, 0, 0, 32'h0);
    mem_acc(1, b, 32'hDEAD_0001, "R5 R10 uncommitted write dropped");
    mem_acc(0, b, 0, "R5 uncommitted read err");
    set_ctrl(0, 0, 1, 0, 32'h0);
    mem_acc(0, b, 0, "R10 word kept after drop");
    idle(3);

    check(q_tag.size() == 0, "R11 all responses seen", 64'(q_tag.size()), 0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule